// File: doc/BRIEF.md
# Tiny Multi-Cycle 8-bit Processor Core

This block is a small load/store processor core with eight 8-bit general registers and a 5-bit program counter. Code and data share one 32-byte RAM, reached through a single synchronous port. Each 16-bit instruction is fetched as two bytes, low byte first. A state machine then latches the instruction, executes it, and for loads adds one read cycle. The instruction set has seven opcodes: add, add-immediate, multiply, load, store, branch-if-equal and branch-if-not-equal. Every other opcode is a no-operation.

A separate loader fills the RAM while `run_en` is low. Raising `run_en` starts execution at address 0. Lowering `run_en` sends the core back to its idle load phase with the PC cleared. The register file keeps its contents across this. Two debug outputs follow the core at all times. One shows the current PC. The other shows the register named by the destination field of the most recently latched instruction.

Top module: `tiny8_core`

## Requirements
- R1: A synchronous active-high `rst` clears all eight registers, the PC and the latched instruction, and puts the core in its idle load phase. In the cycle after reset, `dbg_pc` = 0, `dbg_rd_val` = 0, `mem_addr` = 0 and `mem_we` = 0.
- R2: While `run_en` is low, the core stays idle. It writes neither a register nor RAM, and `dbg_pc` reads 0. Lowering `run_en` during a run returns the core to idle at the next edge with the PC cleared. The register contents are kept.
- R3: The instruction word is {byte at PC+1, byte at PC}. Its fields are: opcode in bits 15:12, bits 11:10 ignored, rd in bits 9:7, rs1 in bits 6:4, and imm/rs2 in bits 3:0. After `run_en` rises, `mem_addr` is PC in the first cycle and PC+1 in the second. The third cycle latches the instruction and the fourth executes it. The next fetch starts in the fifth cycle, and loads take one cycle more.
- R4: Opcode 0000 writes rd = rs1 + rs2 modulo 256. The rs2 index is bits 2:0 of the imm/rs2 field, and bit 3 is ignored.
- R5: Opcode 0001 writes rd = rs1 + imm4, with the 4-bit immediate zero-extended.
- R6: Opcode 0010 writes rd = the low 8 bits of rs1 × rs2.
- R7: Opcode 0011 loads rd from RAM at the low 5 bits of the rs1 value.
- R8: Opcode 0100 writes the rd value to RAM at the low 5 bits of the rs1 value. `mem_we` is high for exactly one cycle.
- R9: Opcode 0101 compares rd with rs1. If they are equal, PC becomes PC + 2 × imm4, where imm4 is signed two's complement, modulo 32. Otherwise PC becomes PC + 2.
- R10: Opcode 0110 takes the same branch as R9 when rd differs from rs1. Otherwise PC becomes PC + 2.
- R11: Opcodes 0111 to 1111 change no register and no RAM, and advance the PC by 2.
- R12: `dbg_rd_val` shows the register named by rd of the latched instruction, and it follows writes to that register. `dbg_pc` shows the PC, which updates at the end of the execute cycle.
- R13: The PC wraps modulo 32, so execution continues from address 0 after the instruction at address 30.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | High to execute, low to idle for loading |
| mem_addr | output | 5 | RAM address for fetch, load or store |
| mem_we | output | 1 | RAM write strobe |
| mem_wdata | output | 8 | RAM write data |
| mem_rdata | input | 8 | RAM read data, one cycle after the address |
| dbg_rd_val | output | 8 | Value of the latched instruction's rd register |
| dbg_pc | output | 5 | Current program counter |

## Verification
Short directed programs each end in a branch-to-self on one register, so `dbg_rd_val` reveals that register. One chain of additions drives the sum past 255, which separates correct wrapping from a widened result. Adding 15 three times separates zero-extension of the immediate from sign-extension. A multiply with bit 3 of the rs2 field set separates correct index truncation and the 8-bit product. A load through the address 60 separates 5-bit address truncation. A program with a skipped forward branch and a counted backward loop separates BEQ from BNE, taken from not taken, and positive from negative offsets. A sweep of every unused opcode that runs off the end of RAM checks both the no-operation behaviour and PC wrap, with cycle-exact sampling of the fetch addresses.

// File: rtl/tiny8_pkg.sv
package tiny8_pkg;

    localparam int DATA_W = 8;
    localparam int PC_W   = 5;
    localparam int RIDX_W = 3;
    localparam int NREGS  = 1 << RIDX_W;
    localparam int OPC_W  = 4;
    localparam int IMM_W  = 4;

    typedef enum logic [OPC_W-1:0] {
        OP_ADD  = 4'd0,
        OP_ADDI = 4'd1,
        OP_MUL  = 4'd2,
        OP_LW   = 4'd3,
        OP_SW   = 4'd4,
        OP_BEQ  = 4'd5,
        OP_BNE  = 4'd6
    } opcode_e;

    // Latched instruction, reserved bits dropped at capture
    typedef struct packed {
        logic [OPC_W-1:0]  opcode;
        logic [RIDX_W-1:0] rd;
        logic [RIDX_W-1:0] rs1;
        logic [IMM_W-1:0]  low4;
    } inst_t;

    typedef enum logic [2:0] {
        ST_LOAD,
        ST_FETCH_LO,
        ST_FETCH_HI,
        ST_DECODE,
        ST_EXEC,
        ST_MEMRD
    } state_t;

    // Control bundle produced from the opcode
    typedef struct packed {
        logic use_imm;
        logic do_mul;
        logic wb_alu;
        logic wb_mem;
        logic store;
        logic branch;
        logic br_ne;
    } ctl_t;

    function automatic ctl_t decode_op(input logic [OPC_W-1:0] op);
        ctl_t c;
        c = '0;
        case (op)
            OP_ADD:  c.wb_alu = 1'b1;
            OP_ADDI: begin c.wb_alu = 1'b1; c.use_imm = 1'b1; end
            OP_MUL:  begin c.wb_alu = 1'b1; c.do_mul = 1'b1; end
            OP_LW:   c.wb_mem = 1'b1;
            OP_SW:   c.store  = 1'b1;
            OP_BEQ:  c.branch = 1'b1;
            OP_BNE:  begin c.branch = 1'b1; c.br_ne = 1'b1; end
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/tiny8_regfile.sv
module tiny8_regfile #(
    parameter int XW = tiny8_pkg::DATA_W,
    parameter int IW = tiny8_pkg::RIDX_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [IW-1:0] waddr,
    input  logic [XW-1:0] wdata,
    input  logic [IW-1:0] raddr_a,
    input  logic [IW-1:0] raddr_b,
    input  logic [IW-1:0] raddr_c,
    output logic [XW-1:0] rdata_a,
    output logic [XW-1:0] rdata_b,
    output logic [XW-1:0] rdata_c
);
    localparam int N = 1 << IW;

    logic [XW-1:0] regs [N];
    logic [N-1:0]  wsel;

    for (genvar g = 0; g < N; g++) begin : g_wsel
        assign wsel[g] = we && (waddr == IW'(g));
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (rst)          regs[i] <= '0;
            else if (wsel[i]) regs[i] <= wdata;
        end
    end

    assign rdata_a = regs[raddr_a];
    assign rdata_b = regs[raddr_b];
    assign rdata_c = regs[raddr_c];
endmodule

// File: rtl/tiny8_alu.sv
module tiny8_alu #(
    parameter int XW = tiny8_pkg::DATA_W,
    parameter int KW = tiny8_pkg::IMM_W
) (
    input  logic [XW-1:0] a,
    input  logic [XW-1:0] b,
    input  logic [XW-1:0] c,
    input  logic [KW-1:0] imm,
    input  logic          use_imm,
    input  logic          do_mul,
    output logic [XW-1:0] res,
    output logic          c_eq_a
);
    logic [XW-1:0] opb;
    logic [XW-1:0] sum;
    logic [XW-1:0] prod;

    assign opb    = use_imm ? XW'(imm) : b;   // zero-extended immediate
    assign sum    = a + opb;
    assign prod   = a * b;                     // low half of the product
    assign res    = do_mul ? prod : sum;
    assign c_eq_a = (c == a);
endmodule

// File: rtl/tiny8_ctrl.sv
module tiny8_ctrl
    import tiny8_pkg::*;
#(
    parameter int AW = PC_W,
    parameter int XW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run_en,
    input  logic [XW-1:0] mem_rdata,
    input  logic [XW-1:0] rs1_val,
    input  logic [XW-1:0] rd_val,
    input  logic [XW-1:0] alu_res,
    input  logic          rd_eq_rs1,
    output inst_t         ir,
    output ctl_t          ctl,
    output state_t        state,
    output logic [AW-1:0] pc,
    output logic [AW-1:0] mem_addr,
    output logic          mem_we,
    output logic [XW-1:0] mem_wdata,
    output logic          rf_we,
    output logic [XW-1:0] rf_wdata
);
    logic [XW-1:0]        lo_q;
    logic                 taken;
    logic signed [IMM_W:0] boff;
    logic [AW-1:0]        next_pc;

    assign ctl   = decode_op(ir.opcode);
    assign taken = ctl.branch && (rd_eq_rs1 != ctl.br_ne);
    assign boff  = {ir.low4, 1'b0};          // signed offset in instructions, doubled
    assign next_pc = pc + (taken ? AW'(boff) : AW'(2));

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_LOAD;
            pc    <= '0;
            lo_q  <= '0;
            ir    <= '0;
        end else if (!run_en) begin
            state <= ST_LOAD;
            pc    <= '0;
        end else begin
            case (state)
                ST_LOAD:     state <= ST_FETCH_LO;
                ST_FETCH_LO: state <= ST_FETCH_HI;
                ST_FETCH_HI: begin
                    lo_q  <= mem_rdata;
                    state <= ST_DECODE;
                end
                ST_DECODE: begin
                    // high byte: opcode in [7:4], two ignored bits in [3:2], rd high bits in [1:0]
                    ir.opcode <= mem_rdata[7:4];
                    ir.rd     <= {mem_rdata[1:0], lo_q[7]};
                    ir.rs1    <= lo_q[6:4];
                    ir.low4   <= lo_q[3:0];
                    state     <= ST_EXEC;
                end
                ST_EXEC: begin
                    pc    <= next_pc;
                    state <= ctl.wb_mem ? ST_MEMRD : ST_FETCH_LO;
                end
                ST_MEMRD: state <= ST_FETCH_LO;
                default:  state <= ST_LOAD;
            endcase
        end
    end

    always_comb begin
        mem_addr = pc;
        case (state)
            ST_FETCH_HI: mem_addr = pc + AW'(1);
            ST_EXEC:     if (ctl.wb_mem || ctl.store) mem_addr = rs1_val[AW-1:0];
            default:     mem_addr = pc;
        endcase
    end

    assign mem_we    = run_en && (state == ST_EXEC) && ctl.store;
    assign mem_wdata = rd_val;
    assign rf_we     = run_en && (((state == ST_EXEC) && ctl.wb_alu) || (state == ST_MEMRD));
    assign rf_wdata  = (state == ST_MEMRD) ? mem_rdata : alu_res;
endmodule

// File: rtl/tiny8_core.sv
module tiny8_core
    import tiny8_pkg::*;
#(
    parameter int AW = PC_W,
    parameter int XW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run_en,
    output logic [AW-1:0] mem_addr,
    output logic          mem_we,
    output logic [XW-1:0] mem_wdata,
    input  logic [XW-1:0] mem_rdata,
    output logic [XW-1:0] dbg_rd_val,
    output logic [AW-1:0] dbg_pc
);
    inst_t         ir;
    ctl_t          ctl;
    state_t        core_state;
    logic [AW-1:0] pc;
    logic [XW-1:0] rs1_val, rs2_val, rd_val, alu_res, rf_wdata;
    logic          rf_we, rd_eq_rs1;

    tiny8_regfile #(.XW(XW), .IW(RIDX_W)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .we      (rf_we),
        .waddr   (ir.rd),
        .wdata   (rf_wdata),
        .raddr_a (ir.rs1),
        .raddr_b (ir.low4[RIDX_W-1:0]),
        .raddr_c (ir.rd),
        .rdata_a (rs1_val),
        .rdata_b (rs2_val),
        .rdata_c (rd_val)
    );

    tiny8_alu #(.XW(XW), .KW(IMM_W)) u_alu (
        .a       (rs1_val),
        .b       (rs2_val),
        .c       (rd_val),
        .imm     (ir.low4),
        .use_imm (ctl.use_imm),
        .do_mul  (ctl.do_mul),
        .res     (alu_res),
        .c_eq_a  (rd_eq_rs1)
    );

    tiny8_ctrl #(.AW(AW), .XW(XW)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .run_en    (run_en),
        .mem_rdata (mem_rdata),
        .rs1_val   (rs1_val),
        .rd_val    (rd_val),
        .alu_res   (alu_res),
        .rd_eq_rs1 (rd_eq_rs1),
        .ir        (ir),
        .ctl       (ctl),
        .state     (core_state),
        .pc        (pc),
        .mem_addr  (mem_addr),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .rf_we     (rf_we),
        .rf_wdata  (rf_wdata)
    );

    assign dbg_rd_val = rd_val;
    assign dbg_pc     = pc;
endmodule

// File: rtl/tiny8_core_chk.sv
module tiny8_core_chk #(
    parameter int AW = tiny8_pkg::PC_W
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 run_en,
    input logic                 mem_we,
    input logic [AW-1:0]        dbg_pc,
    input tiny8_pkg::state_t    st
);
    import tiny8_pkg::*;

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (dbg_pc == '0 && !mem_we && st == ST_LOAD));

    assert_idle_when_off_R2: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> (st == ST_LOAD && dbg_pc == '0 && !mem_we));

    assert_pc_even_R3: assert property (@(posedge clk) disable iff (rst)
        dbg_pc[0] == 1'b0);

    assert_fetch_order_R3: assert property (@(posedge clk) disable iff (rst)
        st == ST_FETCH_LO |=> (st == ST_FETCH_HI || st == ST_LOAD));

    assert_pc_moves_in_exec_R12: assert property (@(posedge clk) disable iff (rst)
        (dbg_pc != $past(dbg_pc)) |-> ($past(st) == ST_EXEC || !$past(run_en)));

    assert_store_in_exec_R8: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> st == ST_EXEC);

    assert_store_single_R8: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we);
endmodule

bind tiny8_core tiny8_core_chk #(.AW(AW)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .run_en (run_en),
    .mem_we (mem_we),
    .dbg_pc (dbg_pc),
    .st     (core_state)
);

// File: tb/tiny8_core_tb.sv
module tiny8_core_tb;
    localparam int CLK_PERIOD = 10;

    localparam logic [3:0] K_ADD = 4'd0, K_ADDI = 4'd1, K_MUL = 4'd2, K_LW = 4'd3,
                           K_SW = 4'd4, K_BEQ = 4'd5, K_BNE = 4'd6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       run_en = 1'b0;
    logic [4:0] mem_addr;
    logic       mem_we;
    logic [7:0] mem_wdata;
    logic [7:0] mem_rdata;
    logic [7:0] dbg_rd_val;
    logic [4:0] dbg_pc;

    logic       ld_en = 1'b0;
    logic [4:0] ld_addr = '0;
    logic [7:0] ld_data = '0;
    logic [7:0] ram [32];

    int checks = 0;
    int failures = 0;
    int we_count = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tiny8_core u_dut (
        .clk        (clk),
        .rst        (rst),
        .run_en     (run_en),
        .mem_addr   (mem_addr),
        .mem_we     (mem_we),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .dbg_rd_val (dbg_rd_val),
        .dbg_pc     (dbg_pc)
    );

    // Synchronous RAM model with a bench-side load port
    always @(posedge clk) begin
        if (ld_en)       ram[ld_addr] <= ld_data;
        else if (mem_we) ram[mem_addr] <= mem_wdata;
        mem_rdata <= ram[mem_addr];
        if (mem_we) we_count <= we_count + 1;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [15:0] enc(input logic [3:0] op, input logic [2:0] rd,
                                        input logic [2:0] rs1, input logic [3:0] lo);
        return {op, 2'b00, rd, rs1, lo};
    endfunction

    task automatic put_byte(input int a, input logic [7:0] d);
        ld_en = 1'b1; ld_addr = 5'(a); ld_data = d;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic put(input int idx, input logic [15:0] w);
        put_byte(2*idx,   w[7:0]);
        put_byte(2*idx+1, w[15:8]);
    endtask

    task automatic prep();
        @(negedge clk);
        rst = 1'b1; run_en = 1'b0;
        tick(2);
        rst = 1'b0;
        for (int i = 0; i < 32; i++) put_byte(i, 8'h00);
    endtask

    task automatic go();
        run_en = 1'b1;
    endtask

    task automatic t_reset();
        prep();
        check("R1 pc after reset", dbg_pc, 0);
        check("R1 rd value after reset", dbg_rd_val, 0);
        check("R1 addr after reset", mem_addr, 0);
        check("R1 we after reset", mem_we, 0);
    endtask

    task automatic t_idle();
        int w0;
        prep();
        put(0, enc(K_ADDI, 3'd1, 3'd0, 4'd5));
        put(1, enc(K_SW, 3'd1, 3'd0, 4'd0));
        w0 = we_count;
        tick(20);
        check("R2 pc held while idle", dbg_pc, 0);
        check("R2 no store while idle", we_count - w0, 0);
        check("R2 no register write while idle", dbg_rd_val, 0);
    endtask

    task automatic t_timing();
        prep();
        put(0, enc(K_ADDI, 3'd1, 3'd0, 4'd5));
        put(1, enc(K_BEQ, 3'd1, 3'd1, 4'd0));
        go();
        tick(1); check("R3 low byte address", mem_addr, 0);
        tick(1); check("R3 high byte address", mem_addr, 1);
        tick(2); check("R12 rd value before writeback", dbg_rd_val, 0);
                 check("R12 pc during execute", dbg_pc, 0);
        tick(1); check("R12 rd value after writeback", dbg_rd_val, 5);
                 check("R3 next fetch pc", dbg_pc, 2);
                 check("R3 next fetch address", mem_addr, 2);
        tick(4); check("R9 self branch holds pc", dbg_pc, 2);
    endtask

    task automatic t_add_wrap();
        prep();
        put(0, enc(K_ADDI, 3'd1, 3'd0, 4'd15));
        put(1, enc(K_ADDI, 3'd2, 3'd1, 4'd15));
        put(2, enc(K_ADD,  3'd3, 3'd2, 4'd2));
        put(3, enc(K_ADD,  3'd3, 3'd3, 4'd3));
        put(4, enc(K_ADD,  3'd3, 3'd3, 4'd3));
        put(5, enc(K_ADD,  3'd4, 3'd3, 4'd3) | 16'h0C00);   // ignored bits set
        put(6, enc(K_BEQ,  3'd4, 3'd4, 4'd0));
        go();
        tick(40);
        check("R4 add chain wraps", dbg_rd_val, 224);
        check("R4 final pc", dbg_pc, 12);
        // R1: reset in the middle of a run clears registers and pc
        rst = 1'b1; run_en = 1'b0;
        tick(1);
        rst = 1'b0;
        check("R1 mid-run reset pc", dbg_pc, 0);
        check("R1 mid-run reset rd value", dbg_rd_val, 0);
    endtask

    task automatic t_addi_zext();
        prep();
        put(0, enc(K_ADDI, 3'd1, 3'd0, 4'd15));
        put(1, enc(K_ADDI, 3'd1, 3'd1, 4'd15));
        put(2, enc(K_ADDI, 3'd1, 3'd1, 4'd15));
        put(3, enc(K_BEQ,  3'd1, 3'd1, 4'd0));
        go();
        tick(30);
        check("R5 immediate zero-extended", dbg_rd_val, 45);
    endtask

    task automatic t_mul();
        prep();
        put(0, enc(K_ADDI, 3'd1, 3'd0, 4'd15));
        put(1, enc(K_ADDI, 3'd1, 3'd1, 4'd15));
        put(2, enc(K_MUL,  3'd2, 3'd1, 4'b1001));            // rs2 index 1
        put(3, enc(K_BEQ,  3'd2, 3'd2, 4'd0));
        go();
        tick(30);
        check("R6 product low byte", dbg_rd_val, 132);
        check("R6 final pc", dbg_pc, 6);
    endtask

    task automatic t_mem();
        int w0;
        prep();
        put_byte(28, 8'hA5);
        put(0, enc(K_ADDI, 3'd1, 3'd0, 4'd14));
        put(1, enc(K_ADD,  3'd1, 3'd1, 4'd1));               // 28
        put(2, enc(K_ADD,  3'd2, 3'd1, 4'd1));               // 56
        put(3, enc(K_ADDI, 3'd2, 3'd2, 4'd4));               // 60 -> address 28
        put(4, enc(K_LW,   3'd3, 3'd2, 4'd0));
        put(5, enc(K_ADDI, 3'd1, 3'd1, 4'd2));               // 30
        put(6, enc(K_SW,   3'd3, 3'd1, 4'd0));
        put(7, enc(K_BEQ,  3'd3, 3'd3, 4'd0));
        w0 = we_count;
        go();
        tick(45);
        check("R7 loaded value", dbg_rd_val, 165);
        check("R8 stored value", ram[30], 165);
        check("R8 source cell untouched", ram[28], 165);
        check("R8 one write strobe", we_count - w0, 1);
        check("R7 final pc", dbg_pc, 14);
    endtask

    task automatic t_branch();
        prep();
        put(0, enc(K_ADDI, 3'd1, 3'd0, 4'd3));
        put(1, enc(K_ADDI, 3'd2, 3'd0, 4'd0));
        put(2, enc(K_BEQ,  3'd1, 3'd2, 4'd5));                // not taken
        put(3, enc(K_BNE,  3'd1, 3'd2, 4'd2));                // taken to 5
        put(4, enc(K_ADDI, 3'd7, 3'd7, 4'd1));                // skipped
        put(5, enc(K_ADDI, 3'd2, 3'd2, 4'd1));
        put(6, enc(K_BNE,  3'd2, 3'd1, 4'hF));                // back to 5
        put(7, enc(K_ADD,  3'd3, 3'd2, 4'd7));
        put(8, enc(K_BEQ,  3'd3, 3'd3, 4'd0));
        go();
        tick(70);
        check("R9 R10 branch program result", dbg_rd_val, 3);
        check("R10 final pc", dbg_pc, 16);
        // R2: dropping run_en returns to idle with pc cleared, registers kept
        run_en = 1'b0;
        tick(1);
        check("R2 pc cleared on stop", dbg_pc, 0);
        tick(5);
        check("R2 registers kept on stop", dbg_rd_val, 3);
    endtask

    task automatic t_nop_wrap();
        int w0;
        prep();
        put(0, enc(K_ADDI, 3'd1, 3'd1, 4'd5));
        for (int i = 1; i < 16; i++)
            put(i, enc(4'(7 + (i % 9)), 3'd1, 3'd1, 4'(i)));
        w0 = we_count;
        go();
        tick(65);
        check("R13 pc wrapped to 0", dbg_pc, 0);
        check("R11 unused opcodes leave register", dbg_rd_val, 5);
        tick(4);
        check("R13 second pass executes", dbg_rd_val, 10);
        check("R11 pc after second pass", dbg_pc, 2);
        check("R11 no stores from unused opcodes", we_count - w0, 0);
    endtask

    initial begin
        t_reset();
        t_idle();
        t_timing();
        t_add_wrap();
        t_addi_zext();
        t_mul();
        t_mem();
        t_branch();
        t_nop_wrap();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        failures++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule